// File: doc/BRIEF.md
# Host controller status register file

This block holds the two status registers of a USB host controller and sits on a simple command-code host bus. The first is an event status register. Hardware event inputs set its bits. Software clears a bit by writing a one to that position, and can never set a bit by writing. A single interrupt line is driven whenever a set bit has its enable input high and the master enable input is also high.

The second register is a command/status word with two parts:
- A two-bit counter of scheduling overruns, which wraps around.
- A software reset request bit. When software writes a one to this bit, the block starts a reset sequence of a fixed number of clock cycles. During the sequence it rejects bus traffic, clears the event status and the overrun count, and gives a one-cycle pulse to the rest of the controller. The request bit clears itself when the sequence ends. The cycle count is a parameter and should be chosen so that the sequence lasts less than 10 microseconds at the clock rate in use.

A transfer is accepted on a cycle where `bus_valid` and `bus_ready` are both high. Bit 7 of the command code selects a write; the other seven bits select the register.

Top module: `hcs_regfile`

## Requirements
- R1: After reset, both registers read as zero, `irq` is 0, `hc_busy` is 0, `hc_rst_pulse` is 0 and `bus_ready` is 1.
- R2: An accepted transfer with command bit 7 clear is a read. On the next cycle `rd_valid` is 1 for one cycle and `rd_data` holds the register contents as they stood before that edge. Code 03h returns the event status, code 02h returns the command/status word, and any other read code returns zero.
- R3: An accepted write with code 83h clears every event status bit whose `bus_wdata` bit is 1. Bits written 0 keep their value, and no write ever sets a bit.
- R4: A high `evt_set[i]` sets status bit i at the next edge. When a write-one-to-clear hits the same bit in the same cycle, the bit ends up set.
- R5: `irq` is 1 exactly when the master enable `irq_master_en` is 1 and some status bit i is set with `irq_en[i]` high. It follows changes on the enable inputs in the same cycle.
- R6: Each cycle with `ovr_evt` high adds one to the overrun count at bits 17:16 of the command/status word, wrapping from 3 to 0. The count still advances when the overrun flag is already set. `ovr_evt` also sets event status bit `OVR_BIT` (bit 0 by default).
- R7: An accepted write with code 82h and `bus_wdata[0]`=1 raises `hc_busy` for exactly `RST_CYCLES` cycles. While `hc_busy` is high, `bus_ready` is 0 and offered transfers are neither accepted nor answered.
- R8: `hc_rst_pulse` is high for exactly the one cycle that follows the reset-starting write.
- R9: The reset sequence zeroes the event status and the overrun count. Events arriving while it runs are dropped, and once it ends, bit 0 of the command/status word reads 0.
- R10: Reserved bits read as 0. In the command/status word only bit 0 is writable, so a write to code 82h with bit 0 clear changes nothing and starts no reset. Event status bits at or above `NEVT` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host offers a transfer |
| bus_ready | output | 1 | Block can accept a transfer (low during soft reset) |
| bus_cmd | input | 8 | Command code; bit 7 set means write |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 32 | Read data |
| evt_set | input | NEVT | Hardware event set strobes, one per status bit |
| ovr_evt | input | 1 | Scheduling-overrun event strobe |
| irq_en | input | NEVT | Per-bit interrupt enables |
| irq_master_en | input | 1 | Master interrupt enable |
| irq | output | 1 | Combined interrupt request |
| hc_busy | output | 1 | Soft reset sequence in progress |
| hc_rst_pulse | output | 1 | One-cycle reset pulse to the controller |

## Verification
The assertions assume that the host treats `bus_ready` as a real gate and does not count a transfer as done until it is accepted. They also assume event strobes are single-cycle levels sampled at the clock edge, and that `bus_cmd` and `bus_wdata` are stable while `bus_valid` is high. The stimulus drives every input on the falling edge and holds each transfer for one rising edge. During the reset sequence it deliberately offers a read, and it fires events, to confirm they are rejected and dropped. A reduced configuration with four status bits allows exhaustive sweeps. These cover every preset pattern, clear mask and same-cycle event pattern, and every combination of status, enable and master enable.

// File: rtl/hcs_pkg.sv
`timescale 1ns/1ps
package hcs_pkg;
  localparam int          DATA_W   = 32;
  localparam int          CODE_W   = 8;
  localparam int          WR_FLAG  = 7;
  localparam logic [6:0]  SEL_STS  = 7'h03;
  localparam logic [6:0]  SEL_CTL  = 7'h02;
  localparam int          OVR_LSB  = 16;
  localparam int          OVR_W    = 2;
  localparam int          SRST_BIT = 0;

  typedef struct packed {
    logic rd_any;
    logic rd_sts;
    logic rd_ctl;
    logic wr_sts;
    logic wr_ctl;
  } hcs_acc_t;
endpackage

// File: rtl/hcs_cmd_decode.sv
`timescale 1ns/1ps
module hcs_cmd_decode
  import hcs_pkg::*;
(
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [CODE_W-1:0] cmd_i,
  output hcs_acc_t          acc_o
);
  logic       take;
  logic       is_wr;
  logic [6:0] sel;

  always_comb begin
    take         = valid_i & ready_i;
    is_wr        = cmd_i[WR_FLAG];
    sel          = cmd_i[6:0];
    acc_o.rd_any = take & ~is_wr;
    acc_o.rd_sts = take & ~is_wr & (sel == SEL_STS);
    acc_o.rd_ctl = take & ~is_wr & (sel == SEL_CTL);
    acc_o.wr_sts = take &  is_wr & (sel == SEL_STS);
    acc_o.wr_ctl = take &  is_wr & (sel == SEL_CTL);
  end
endmodule

// File: rtl/hcs_irq_status.sv
`timescale 1ns/1ps
module hcs_irq_status #(
  parameter int NEVT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_i,
  input  logic            clr_we_i,
  input  logic [NEVT-1:0] clr_mask_i,
  input  logic [NEVT-1:0] evt_i,
  output logic [NEVT-1:0] sts_o
);
  logic [NEVT-1:0] sts_q;
  logic [NEVT-1:0] sts_d;
  logic            sts_en;

  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    always_comb begin
      if (hold_i) sts_d[i] = 1'b0;
      else        sts_d[i] = evt_i[i] | (sts_q[i] & ~(clr_we_i & clr_mask_i[i]));
    end
  end

  always_comb sts_en = hold_i | clr_we_i | (|evt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  AST_HOST_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt_i)) == '0)); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && (evt_i != '0)) |=> ((sts_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (sts_q == '0)); // R9
endmodule

// File: rtl/hcs_ctrl_status.sv
`timescale 1ns/1ps
module hcs_ctrl_status
  import hcs_pkg::*;
#(
  parameter int RST_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl_i,
  input  logic             wr_srst_i,
  input  logic             ovr_evt_i,
  output logic [OVR_W-1:0] ovr_cnt_o,
  output logic             srst_req_o,
  output logic             srst_pulse_o,
  output logic             hold_o
);
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

  logic             req_q,   req_d;
  logic [CW-1:0]    cnt_q,   cnt_d;
  logic [OVR_W-1:0] ovr_q,   ovr_d;
  logic             pulse_q, pulse_d;
  logic             start;
  logic             done;
  logic             state_en;

  always_comb begin
    start = wr_ctl_i & wr_srst_i & ~req_q;
    done  = req_q & (cnt_q == '0);

    req_d = req_q;
    if (start)     req_d = 1'b1;
    else if (done) req_d = 1'b0;

    cnt_d = cnt_q;
    if (start)                     cnt_d = CNT_LOAD;
    else if (req_q && !done)       cnt_d = cnt_q - 1'b1;

    ovr_d = ovr_q;
    if (start || req_q) ovr_d = '0;
    else if (ovr_evt_i) ovr_d = ovr_q + 1'b1;

    pulse_d  = start;
    state_en = start | req_q | ovr_evt_i | pulse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cnt_q   <= '0;
      ovr_q   <= '0;
      pulse_q <= 1'b0;
    end else if (state_en) begin
      req_q   <= req_d;
      cnt_q   <= cnt_d;
      ovr_q   <= ovr_d;
      pulse_q <= pulse_d;
    end
  end

  assign ovr_cnt_o    = ovr_q;
  assign srst_req_o   = req_q;
  assign srst_pulse_o = pulse_q;
  assign hold_o       = start | req_q;

  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt_i && !hold_o) |=> (ovr_q == $past(ovr_q) + 2'd1)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R8
  AST_REQ_ENDS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> (cnt_q == '0)); // R7
  AST_OVR_ZERO_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> (ovr_q == '0)); // R9
endmodule

// File: rtl/hcs_regfile.sv
`timescale 1ns/1ps
module hcs_regfile
  import hcs_pkg::*;
#(
  parameter int NEVT       = 8,
  parameter int RST_CYCLES = 64,
  parameter int OVR_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [7:0]        bus_cmd,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [NEVT-1:0]   evt_set,
  input  logic              ovr_evt,
  input  logic [NEVT-1:0]   irq_en,
  input  logic              irq_master_en,
  output logic              irq,
  output logic              hc_busy,
  output logic              hc_rst_pulse
);
  hcs_acc_t         acc;
  logic [NEVT-1:0]  sts;
  logic [NEVT-1:0]  evt_all;
  logic [OVR_W-1:0] ovr_cnt;
  logic             srst_req;
  logic             hold;
  logic [31:0]      rd_d;
  logic [31:0]      rd_q;
  logic             rdv_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign bus_ready    = ~srst_req;

  hcs_cmd_decode u_dec (
    .valid_i (bus_valid),
    .ready_i (bus_ready),
    .cmd_i   (bus_cmd),
    .acc_o   (acc)
  );

  always_comb begin
    evt_all          = evt_set;
    evt_all[OVR_BIT] = evt_set[OVR_BIT] | ovr_evt;
  end

  hcs_irq_status #(.NEVT(NEVT)) u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold),
    .clr_we_i   (acc.wr_sts),
    .clr_mask_i (bus_wdata[NEVT-1:0]),
    .evt_i      (evt_all),
    .sts_o      (sts)
  );

  hcs_ctrl_status #(.RST_CYCLES(RST_CYCLES)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctl_i     (acc.wr_ctl),
    .wr_srst_i    (bus_wdata[SRST_BIT]),
    .ovr_evt_i    (ovr_evt),
    .ovr_cnt_o    (ovr_cnt),
    .srst_req_o   (srst_req),
    .srst_pulse_o (hc_rst_pulse),
    .hold_o       (hold)
  );

  always_comb begin
    rd_d = '0;
    if (acc.rd_sts) begin
      rd_d[NEVT-1:0] = sts;
    end else if (acc.rd_ctl) begin
      rd_d[OVR_LSB +: OVR_W] = ovr_cnt;
      rd_d[SRST_BIT]         = srst_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= acc.rd_any;
      if (acc.rd_any) rd_q <= rd_d;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rd_q;
  assign hc_busy  = srst_req;
  assign irq      = irq_master_en & (|(sts & irq_en));

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_cmd[WR_FLAG]) |=> rd_valid); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> !rd_valid); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> !irq); // R5
endmodule

// File: tb/test_hcs_regfile.sv
`timescale 1ns/1ps
module test_hcs_regfile;
  localparam int NEVT = 4;
  localparam int RSTC = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_valid;
  logic            bus_ready;
  logic [7:0]      bus_cmd;
  logic [31:0]     bus_wdata;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic [NEVT-1:0] evt_set;
  logic            ovr_evt;
  logic [NEVT-1:0] irq_en;
  logic            irq_master_en;
  logic            irq;
  logic            hc_busy;
  logic            hc_rst_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  hcs_regfile #(.NEVT(NEVT), .RST_CYCLES(RSTC), .OVR_BIT(0)) i_hcs_regfile (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .evt_set(evt_set), .ovr_evt(ovr_evt), .irq_en(irq_en),
    .irq_master_en(irq_master_en), .irq(irq), .hc_busy(hc_busy),
    .hc_rst_pulse(hc_rst_pulse)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] cmd, logic [31:0] d, logic [NEVT-1:0] ev);
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = cmd; bus_wdata = d; evt_set = ev;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; evt_set = '0;
  endtask

  task automatic bus_rd(logic [7:0] cmd, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = cmd; bus_wdata = '0;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic fire(logic [NEVT-1:0] ev, logic ovr);
    @(negedge clk);
    evt_set = ev; ovr_evt = ovr;
    @(posedge clk);
    @(negedge clk);
    evt_set = '0; ovr_evt = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    int          n;
    rst_n = 1'b0; bus_valid = 1'b0; bus_cmd = '0; bus_wdata = '0;
    evt_set = '0; ovr_evt = 1'b0; irq_en = '0; irq_master_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, bus_ready}, 32'd1);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 busy", {31'b0, hc_busy}, 32'd0);
    chk("R1 pulse", {31'b0, hc_rst_pulse}, 32'd0);
    bus_rd(8'h03, d, v); chk("R1 sts", d, 32'd0);
    bus_rd(8'h02, d, v); chk("R1 ctl", d, 32'd0);
    // R2 read answering and unknown code
    bus_rd(8'h05, d, v);
    chk("R2 rd_valid", {31'b0, v}, 32'd1);
    chk("R2 unknown code", d, 32'd0);
    @(negedge clk); chk("R2 one cycle", {31'b0, rd_valid}, 32'd0);

    // R3 / R4 exhaustive sweep: preset a, clear mask b, same-cycle event c
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          bus_wr(8'h83, 32'hF, '0);
          fire(4'(a), 1'b0);
          bus_wr(8'h83, 32'(b), 4'(c));
          bus_rd(8'h03, d, v);
          if (c == 0) chk("R3 w1c", d, 32'((a & ~b) & 15));
          else        chk("R4 set wins", d, 32'(((a & ~b) | c) & 15));
        end

    // R10 upper status bits read zero
    fire(4'hF, 1'b0);
    bus_wr(8'h83, 32'hFFFF_FFF0, '0);
    bus_rd(8'h03, d, v); chk("R10 status upper bits", d, 32'hF);

    // R5 interrupt masking sweep
    for (int s = 0; s < 16; s++) begin
      bus_wr(8'h83, 32'hF, '0);
      fire(4'(s), 1'b0);
      for (int e = 0; e < 16; e++)
        for (int m = 0; m < 2; m++) begin
          @(negedge clk);
          irq_en = 4'(e); irq_master_en = m[0];
          #1;
          chk("R5 irq", {31'b0, irq}, {31'b0, (m == 1) && ((s & e) != 0)});
        end
    end
    irq_en = '0; irq_master_en = 1'b0;

    // R6 overrun count wraps and keeps counting with flag set
    bus_wr(8'h83, 32'hF, '0);
    for (int k = 1; k < 10; k++) begin
      fire('0, 1'b1);
      bus_rd(8'h02, d, v); chk("R6 ovr count", d, 32'(k % 4) << 16);
      bus_rd(8'h03, d, v); chk("R6 ovr flag", d & 32'h1, 32'h1);
    end

    // R10 only bit 0 writable, bit0=0 starts nothing
    bus_wr(8'h82, 32'hFFFF_FFFE, '0);
    chk("R10 no reset", {31'b0, hc_busy}, 32'd0);
    bus_rd(8'h02, d, v); chk("R10 ctl unchanged", d, 32'h0001_0000);

    // R7 / R8 / R9 reset sequence
    fire(4'hF, 1'b0);
    bus_wr(8'h82, 32'h1, '0);
    chk("R8 pulse high", {31'b0, hc_rst_pulse}, 32'd1);
    chk("R7 ready low", {31'b0, bus_ready}, 32'd0);
    n = 0;
    while (hc_busy && n < 1000) begin
      n++;
      if (n == 2) chk("R8 pulse low", {31'b0, hc_rst_pulse}, 32'd0);
      if (n == 3) begin
        bus_valid = 1'b1; bus_cmd = 8'h03; evt_set = 4'hF; ovr_evt = 1'b1;
      end
      if (n == 4) begin
        bus_valid = 1'b0; evt_set = '0; ovr_evt = 1'b0;
        chk("R7 rejected read", {31'b0, rd_valid}, 32'd0);
      end
      @(negedge clk);
    end
    chk("R7 busy length", 32'(n), 32'(RSTC));
    chk("R7 ready after", {31'b0, bus_ready}, 32'd1);
    bus_rd(8'h03, d, v); chk("R9 sts cleared", d, 32'd0);
    bus_rd(8'h02, d, v); chk("R9 ctl cleared", d, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule